// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

This block moves 8-bit characters over a three-wire clocked link made of a serial clock, a transmit line and a receive line. On the transmit side a host writes a byte into a holding register, and that write clears an empty flag. The block sees the cleared flag and copies the byte into a shift register. It then sets the flag again and sends the bits least-significant first. Each bit changes on a falling serial-clock edge. The receive side captures one bit on every rising serial-clock edge. After eight bits it presents the byte and raises a full flag, which the host clears with an acknowledge pulse.

The serial clock comes from one of two places. The first is an internal divider, whose half period is the programmed value plus one system clocks; in this case the block drives the clock pin. The second is an external clock that the block follows through a synchronizer. The clock rests high between characters. When the host refills the holding register before a character ends, the next character follows with no extra high time. Two interrupt requests follow the flags when their enables are set: one while the transmit holding register is empty, and one while a received byte is waiting.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset, sck_out is high, txd is high, tx_empty is 1, rx_full is 0 and both interrupt requests are 0.
- R2: With cfg_ext_clk = 0 the block drives sck_oe = 1. It sends exactly 8 low pulses on sck_out per character, and each high or low half period between pulses lasts cfg_div + 1 clk cycles.
- R3: A character's bits appear on txd least-significant first (bit 0 at the first pulse). txd changes only after a falling serial-clock edge, so it is stable at each rising edge.
- R4: After the eighth bit, txd keeps the value of bit 7 until a later character drives its first bit.
- R5: A host_wr pulse stores host_data and clears tx_empty. When tx_empty is 0 and no character is in progress, the block loads the shift register on the next clk edge and sets tx_empty to 1. A host_wr in that same cycle keeps tx_empty at 0.
- R6: If tx_empty is 0 when the eighth rising edge of a character occurs, the next character is loaded on that edge. The first falling edge of the new character follows after one normal half period (cfg_div + 1 cycles), with no added high gap.
- R7: While no character is in progress, sck_out stays high.
- R8: The receiver shifts in rxd on each rising serial-clock edge, least-significant first. On the eighth edge it presents the byte on rx_data and sets rx_full.
- R9: An rx_ack pulse clears rx_full. If rx_ack arrives in the same cycle that a byte completes, rx_full ends up 1 with the new byte.
- R10: With cfg_ext_clk = 1, sck_oe is 0. txd advances on falling edges of sck_in and rxd is sampled on rising edges of sck_in, after a two-flop synchronizer.
- R11: tx_irq equals tx_empty when cfg_tie = 1 and is 0 when cfg_tie = 0. rx_irq equals rx_full when cfg_rie = 1 and is 0 when cfg_rie = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ext_clk | input | 1 | 0 selects the internal divider, 1 selects sck_in |
| cfg_div | input | DIV_W | Half-period length minus one, in clk cycles |
| cfg_tie | input | 1 | Transmit-empty interrupt enable |
| cfg_rie | input | 1 | Receive-full interrupt enable |
| host_wr | input | 1 | Write strobe for the transmit holding register |
| host_data | input | CHAR_W | Byte to transmit |
| tx_empty | output | 1 | Transmit holding register empty flag |
| rx_ack | input | 1 | Clears rx_full |
| rx_data | output | CHAR_W | Last received byte |
| rx_full | output | 1 | Received byte waiting |
| tx_irq | output | 1 | Transmit-empty interrupt request |
| rx_irq | output | 1 | Receive-full interrupt request |
| sck_in | input | 1 | External serial clock |
| sck_out | output | 1 | Internally generated serial clock |
| sck_oe | output | 1 | Serial clock output enable |
| txd | output | 1 | Serial transmit data |
| rxd | input | 1 | Serial receive data |

## Verification
The eighth rising edge of a character is a single clk edge at which two events can fall together. In continuous transmission, the receiver completes its byte and the transmitter reloads from the holding register on that edge. The bench refills the register during the first character and then checks, in the sample right after that edge, that rx_full and tx_empty are both 1 and that the clock high time has not grown. A second collision is an acknowledge pulse that lands on a receive completion. With a divider of zero the bench raises rx_ack just before the final rising edge and expects rx_full to stay set with the new byte.

// File: rtl/sync_ser_pkg.sv
// Package: shared types for the synchronous serial transceiver.
// Assumes: nothing beyond IEEE 1800-2017.
package sync_ser_pkg;

    // Serial clock source selection
    typedef enum logic {
        SRC_INT = 1'b0,
        SRC_EXT = 1'b1
    } sck_src_e;

endpackage

// File: rtl/sync_sck_baud.sv
// Internal serial clock generator. While run is high it toggles sck every
// div+1 clk cycles and flags each falling or rising toggle with a one-cycle
// pulse. While run is low it holds sck high and restarts its count.
// Assumes: div is stable while run is high.
module sync_sck_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             sck,
    output logic             fall_p,
    output logic             rise_p
);

    logic [DIV_W-1:0] cnt;
    logic             tick;

    // Half-period expiry
    always_comb tick = run && (cnt == div);

    // Edge pulses: a toggle from high is a fall, from low is a rise
    always_comb begin
        fall_p = tick && sck;
        rise_p = tick && !sck;
    end

    // Divider counter and clock level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            sck <= 1'b1;
        end else if (!run) begin
            cnt <= '0;
            sck <= 1'b1;
        end else if (tick) begin
            cnt <= '0;
            sck <= !sck;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !$past(run)) |-> sck); // R7

endmodule

// File: rtl/sync_sck_edge.sv
// External serial clock follower. Passes sck_in through SYNC_STAGES flops
// and compares the last synchronized level with the one before it to give
// one-cycle fall and rise pulses in the clk domain.
// Assumes: SYNC_STAGES >= 2, sck_in half periods longer than a few clk cycles.
module sync_sck_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_in,
    output logic fall_p,
    output logic rise_p
);

    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh;

    // Synchronizer chain plus one history flop, idle high
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '1;
        else        sh <= {sh[SH_W-2:0], sck_in};
    end

    // Edge detection on the synchronized level
    always_comb begin
        fall_p = sh[SH_W-1] && !sh[SH_W-2];
        rise_p = !sh[SH_W-1] && sh[SH_W-2];
    end

endmodule

// File: rtl/sync_tx_shift.sv
// Transmitter: holding register, empty flag and LSB-first shift register.
// Loads when the flag is clear and no character runs, or on the last rising
// edge of a character for back-to-back output. Drives a new bit on each
// falling edge and holds the last bit when done.
// Assumes: fall_p and rise_p are never high in the same cycle.
module sync_tx_shift #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [CHAR_W-1:0] host_data,
    input  logic              fall_p,
    input  logic              rise_p,
    output logic              txd,
    output logic              tx_empty,
    output logic              busy
);

    localparam int CNT_W = $clog2(CHAR_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAR_W - 1);

    logic [CHAR_W-1:0] hold_q;
    logic [CHAR_W-1:0] shreg;
    logic [CNT_W-1:0]  rcnt;
    logic              frame_end;
    logic              load;

    // Character completion and reload decision
    always_comb begin
        frame_end = busy && rise_p && (rcnt == LAST);
        load      = !tx_empty && (!busy || frame_end);
    end

    // Holding register and empty flag (host write wins over load)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q   <= '0;
            tx_empty <= 1'b1;
        end else begin
            if (host_wr) hold_q <= host_data;
            if (host_wr)   tx_empty <= 1'b0;
            else if (load) tx_empty <= 1'b1;
        end
    end

    // Busy state and rising-edge bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            rcnt <= '0;
        end else if (load) begin
            busy <= 1'b1;
            rcnt <= '0;
        end else if (frame_end) begin
            busy <= 1'b0;
            rcnt <= '0;
        end else if (busy && rise_p) begin
            rcnt <= rcnt + 1'b1;
        end
    end

    // Shift register and output bit, advanced on falling edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            txd   <= 1'b1;
        end else if (load) begin
            shreg <= hold_q;
        end else if (busy && fall_p) begin
            txd   <= shreg[0];
            shreg <= shreg >> 1;
        end
    end

    AST_TXD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(txd) |-> $past(fall_p && busy)); // R3
    AST_HOLD_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $stable(txd)); // R4
    AST_LOAD_SETS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load) |-> (tx_empty || $past(host_wr))); // R5

endmodule

// File: rtl/sync_rx_shift.sv
// Receiver: shifts rxd in LSB first on each rising serial edge and, after
// CHAR_W edges, copies the byte out and sets the full flag. Completion
// takes priority over an acknowledge in the same cycle.
// Assumes: rxd is stable at the rising edge pulse.
module sync_rx_shift #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_p,
    input  logic              rxd,
    input  logic              ack,
    output logic [CHAR_W-1:0] rx_data,
    output logic              rx_full
);

    localparam int CNT_W = $clog2(CHAR_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAR_W - 1);

    logic [CHAR_W-1:0] shreg;
    logic [CNT_W-1:0]  rcnt;
    logic              done;

    // Eighth sample of a character
    always_comb done = rise_p && (rcnt == LAST);

    // Input shift register and bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            rcnt  <= '0;
        end else if (rise_p) begin
            shreg <= {rxd, shreg[CHAR_W-1:1]};
            rcnt  <= done ? '0 : rcnt + 1'b1;
        end
    end

    // Output byte and full flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
            rx_full <= 1'b0;
        end else begin
            if (done) rx_data <= {rxd, shreg[CHAR_W-1:1]};
            if (done)     rx_full <= 1'b1;
            else if (ack) rx_full <= 1'b0;
        end
    end

    AST_FULL_ON_LAST_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> $past(rise_p)); // R8
    AST_DONE_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(done && ack) |-> rx_full); // R9

endmodule

// File: rtl/sync_serial_xcvr.sv
// Top of the clocked synchronous serial transceiver. Selects the serial
// clock source, routes its edge pulses to the transmitter and receiver, and
// forms the interrupt requests from the flags.
// Assumes: cfg_ext_clk and cfg_div change only while no character runs.
module sync_serial_xcvr
    import sync_ser_pkg::*;
#(
    parameter int CHAR_W      = 8,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_ext_clk,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              cfg_tie,
    input  logic              cfg_rie,
    input  logic              host_wr,
    input  logic [CHAR_W-1:0] host_data,
    output logic              tx_empty,
    input  logic              rx_ack,
    output logic [CHAR_W-1:0] rx_data,
    output logic              rx_full,
    output logic              tx_irq,
    output logic              rx_irq,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    output logic              txd,
    input  logic              rxd
);

    sck_src_e src;
    logic     busy;
    logic     int_run;
    logic     int_fall, int_rise;
    logic     ext_fall, ext_rise;
    logic     fall_sel, rise_sel;

    // Clock source decode and edge routing
    always_comb begin
        src      = sck_src_e'(cfg_ext_clk);
        int_run  = busy && (src == SRC_INT);
        fall_sel = (src == SRC_EXT) ? ext_fall : int_fall;
        rise_sel = (src == SRC_EXT) ? ext_rise : int_rise;
        sck_oe   = (src == SRC_INT);
    end

    // Interrupt requests gated by their enables
    always_comb begin
        tx_irq = cfg_tie && tx_empty;
        rx_irq = cfg_rie && rx_full;
    end

    sync_sck_baud #(.DIV_W(DIV_W)) u_baud (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (int_run),
        .div    (cfg_div),
        .sck    (sck_out),
        .fall_p (int_fall),
        .rise_p (int_rise)
    );

    sync_sck_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck_in (sck_in),
        .fall_p (ext_fall),
        .rise_p (ext_rise)
    );

    sync_tx_shift #(.CHAR_W(CHAR_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_wr   (host_wr),
        .host_data (host_data),
        .fall_p    (fall_sel),
        .rise_p    (rise_sel),
        .txd       (txd),
        .tx_empty  (tx_empty),
        .busy      (busy)
    );

    sync_rx_shift #(.CHAR_W(CHAR_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_p  (rise_sel),
        .rxd     (rxd),
        .ack     (rx_ack),
        .rx_data (rx_data),
        .rx_full (rx_full)
    );

    AST_EXT_NO_INT_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ext_clk |-> !(int_fall || int_rise)); // R10

endmodule

// File: tb/tb_sync_serial_xcvr.sv
module tb_sync_serial_xcvr;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_ext_clk = 1'b0;
    logic [7:0] cfg_div = 8'd0;
    logic       cfg_tie = 1'b0;
    logic       cfg_rie = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_data = 8'd0;
    logic       tx_empty;
    logic       rx_ack = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full;
    logic       tx_irq, rx_irq;
    logic       sck_in = 1'b1;
    logic       sck_out, sck_oe, txd;
    logic       rxd = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = !clk;

    sync_serial_xcvr dut (
        .clk(clk), .rst_n(rst_n), .cfg_ext_clk(cfg_ext_clk), .cfg_div(cfg_div),
        .cfg_tie(cfg_tie), .cfg_rie(cfg_rie), .host_wr(host_wr),
        .host_data(host_data), .tx_empty(tx_empty), .rx_ack(rx_ack),
        .rx_data(rx_data), .rx_full(rx_full), .tx_irq(tx_irq), .rx_irq(rx_irq),
        .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe), .txd(txd), .rxd(rxd)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sck_out == 1'b1, "R1 sck_out", sck_out, 1);
        chk(txd == 1'b1, "R1 txd", txd, 1);
        chk(tx_empty == 1'b1 && rx_full == 1'b0, "R1 flags", {tx_empty, rx_full}, 2'b10);
        chk(tx_irq == 1'b0 && rx_irq == 1'b0, "R1 irqs", {tx_irq, rx_irq}, 0);
    endtask

    task automatic t_idle();
        bit hi_ok = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (sck_out !== 1'b1) hi_ok = 1'b0;
        end
        chk(hi_ok, "R7 idle clock high", hi_ok, 1);
    endtask

    // Internal-clock transfer of one or two characters, receiving r0/r1.
    task automatic t_int(input logic [7:0] d0, input logic [7:0] d1, input int nfr,
                         input int div, input logic [7:0] r0, input logic [7:0] r1,
                         input bit clash);
        logic [15:0] got = '0;
        logic [15:0] rpat = {r1, r0};
        logic [15:0] dpat = {d1, d0};
        int pulses = 0, rises = 0, hi = 0, lo = 0, idle = 0;
        logic prev = 1'b1, s;
        bit per_ok = 1'b1;
        cfg_ext_clk = 1'b0;
        cfg_div = div[7:0];
        @(negedge clk);
        host_wr = 1'b1; host_data = d0;
        @(negedge clk);
        host_wr = 1'b0;
        chk(tx_empty == 1'b0, "R5 write clears empty", tx_empty, 0);
        @(negedge clk);
        chk(tx_empty == 1'b1, "R5 load sets empty", tx_empty, 1);
        chk(sck_oe == 1'b1, "R2 drives clock", sck_oe, 1);
        for (int c = 0; c < 4000; c++) begin
            if (c > 0) @(negedge clk);
            if (c == 0 && nfr == 2) begin host_wr = 1'b1; host_data = d1; end
            if (c == 1) host_wr = 1'b0;
            s = sck_out;
            if (prev && !s) begin
                if (pulses > 0 && hi != div + 1) per_ok = 1'b0;
                hi = 0;
                pulses++;
                if (pulses <= 16) rxd = rpat[pulses-1];
                if (pulses == 8 && nfr == 2)
                    chk(tx_empty == 1'b0, "R6 next byte pending", tx_empty, 0);
                if (clash && pulses == 16) rx_ack = 1'b1;
            end
            if (!prev && s) begin
                if (lo != div + 1) per_ok = 1'b0;
                lo = 0;
                if (rises < 16) got[rises] = txd;
                rises++;
                rx_ack = 1'b0;
                if (rises == 8) begin
                    chk(rx_full == 1'b1 && rx_data == r0, "R8 first byte received",
                        {rx_full, rx_data}, {1'b1, r0});
                    if (nfr == 2)
                        chk(tx_empty == 1'b1 && rx_full == 1'b1,
                            "R6 reload and receive same edge", {tx_empty, rx_full}, 2'b11);
                end
                if (rises == 16)
                    chk(rx_full == 1'b1 && rx_data == r1, "R9 completion beats ack",
                        {rx_full, rx_data}, {1'b1, r1});
            end
            if (s) hi++; else lo++;
            if (rises >= 8 * nfr) idle++;
            if (idle > 4 * (div + 1) + 4) break;
            prev = s;
        end
        chk(pulses == 8 * nfr, "R2 pulse count", pulses, 8 * nfr);
        chk(per_ok, "R2 R6 half periods", per_ok, 1);
        if (nfr == 2) chk(got == dpat, "R3 bit order two bytes", got, dpat);
        else chk(got[7:0] == d0, "R3 bit order", got[7:0], d0);
        chk(txd == dpat[8*nfr-1], "R4 last bit held", txd, dpat[8*nfr-1]);
        repeat (10) @(negedge clk);
        chk(txd == dpat[8*nfr-1] && sck_out == 1'b1, "R4 R7 hold after frame",
            {txd, sck_out}, {dpat[8*nfr-1], 1'b1});
    endtask

    task automatic t_ack();
        @(negedge clk); rx_ack = 1'b1;
        @(negedge clk); rx_ack = 1'b0;
        chk(rx_full == 1'b0, "R9 ack clears full", rx_full, 0);
    endtask

    task automatic t_irq();
        cfg_tie = 1'b1; cfg_rie = 1'b0;
        @(negedge clk);
        chk(tx_irq == tx_empty && rx_irq == 1'b0, "R11 tx irq enabled, rx masked",
            {tx_irq, rx_irq}, {tx_empty, 1'b0});
        cfg_tie = 1'b0; cfg_rie = 1'b1;
        @(negedge clk);
        chk(tx_irq == 1'b0 && rx_irq == rx_full, "R11 tx masked, rx enabled",
            {tx_irq, rx_irq}, {1'b0, rx_full});
        cfg_rie = 1'b0;
    endtask

    task automatic t_ext(input logic [7:0] d, input logic [7:0] r);
        logic [7:0] got = '0;
        cfg_ext_clk = 1'b1;
        sck_in = 1'b1;
        @(negedge clk);
        host_wr = 1'b1; host_data = d;
        @(negedge clk);
        host_wr = 1'b0;
        repeat (2) @(negedge clk);
        chk(tx_empty == 1'b1 && sck_oe == 1'b0, "R10 loaded, clock not driven",
            {tx_empty, sck_oe}, 2'b10);
        for (int i = 0; i < 8; i++) begin
            sck_in = 1'b0;
            repeat (6) @(negedge clk);
            got[i] = txd;
            rxd = r[i];
            sck_in = 1'b1;
            repeat (6) @(negedge clk);
        end
        chk(got == d, "R10 ext transmit order", got, d);
        chk(rx_full == 1'b1 && rx_data == r, "R10 ext receive", {rx_full, rx_data}, {1'b1, r});
        repeat (10) @(negedge clk);
        chk(txd == d[7] && sck_out == 1'b1, "R4 ext last bit held", {txd, sck_out}, {d[7], 1'b1});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_idle();
        t_int(8'hA5, 8'h00, 1, 2, 8'h3C, 8'h00, 1'b0);
        t_irq();
        t_ack();
        t_int(8'h01, 8'h80, 2, 0, 8'hF0, 8'h0F, 1'b1);
        t_ack();
        t_int(8'h6E, 8'h00, 1, 5, 8'h96, 8'h00, 1'b0);
        t_ack();
        t_ext(8'h4B, 8'hD2);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule